// File: doc/BRIEF.md
# I2C Transmit Double-Buffer Controller

This block sits between a CPU and the byte shifter of an I2C-style serial interface and handles the transmit direction only. The CPU writes each outgoing byte into a holding register. The block moves that byte into a shift register when the shifter can take it. An internal "transmit data empty" flag tells the CPU when the holding register may take the next byte. Software can neither read nor write the flag directly. It is shown at the output only while the interface is in transmit mode.

The bus engine signals events as single-cycle strobes: a start condition was seen, a stop condition was seen, and a byte ended (the rising edge of the ninth clock). With each byte end comes the acknowledge bit it received. If the ack-check control is on, a not-acknowledged byte keeps the flag from being set and holds the pending byte back. If a byte ends while the holding register is already empty, the shifter waits idle. The next CPU write is then moved across one cycle after it lands, so the flag goes low for one cycle and then comes back. A stop condition or a low module-enable clears the flag, and either one wins over every other event in the same cycle.

Top module: `txbuf_ctl`

## Requirements
- R1: After a synchronous active-low reset, `tx_empty` is 0, `load_pulse` is 0 and `shift_q` is all zeros.
- R2: A CPU write (`wr_stb`=1) is accepted only while `xmit_mode`=1 and `mod_en`=1. An accepted write stores `wr_data` in the holding register, and the flag reads 0 after that edge.
- R3: Each load copies the holding register into `shift_q`, sets the flag to 1 and raises `load_pulse` for exactly one cycle. All three change on the same clock edge.
- R4: A `start_seen` strobe sets the flag to 1 at the next edge and marks the shifter free, so the next accepted write is loaded on its own.
- R5: A `byte_done` strobe while the flag is 0 and the byte is not held back causes a load at that edge.
- R6: A `byte_done` strobe while the flag is 1 leaves the shifter idle. The next accepted write makes the flag 0 for one cycle, and one edge later the load of R3 takes place.
- R7: With `ack_chk_en`=1 and `ack_bit`=1 at `byte_done`, the flag is not set and no load happens. With `ack_chk_en`=0, `ack_bit` has no effect.
- R8: `stop_seen`=1 or `mod_en`=0 makes the flag 0 at the next edge and cancels any idle-shifter state.
- R9: `tx_empty` equals the internal flag while `xmit_mode`=1 and reads 0 while `xmit_mode`=0.
- R10: A write with `xmit_mode`=0 or `mod_en`=0 changes neither the holding register nor the flag.
- R11: When `stop_seen` or a low `mod_en` occurs in the same cycle as a start, a write or a pending load, the flag becomes 0 and no load happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | CPU write strobe for transmit data |
| wr_data | input | DATA_W | Byte written by the CPU |
| xmit_mode | input | 1 | 1 = transmit mode |
| mod_en | input | 1 | Module enable; 0 clears the flag |
| ack_chk_en | input | 1 | Enables hold-back on a received NACK |
| byte_done | input | 1 | Strobe at the ninth-clock rising edge |
| start_seen | input | 1 | Start-condition strobe |
| stop_seen | input | 1 | Stop-condition strobe |
| ack_bit | input | 1 | Received acknowledge bit (1 = NACK) |
| shift_q | output | DATA_W | Shift register contents |
| load_pulse | output | 1 | One-cycle pulse per shift-register load |
| tx_empty | output | 1 | Transmit-data-empty flag, gated by mode |

## Verification
Every result of a strobe or write (flag, pulse and shift contents) is due at the first rising edge after the cycle in which the stimulus is driven. The one exception is the refill load of R6, which lands one edge after the flag drops. The driver applies inputs on the falling edge and queues the values due after the next rising edge. The monitor checks them 2 ns after that rising edge. This way every check falls exactly one edge after its stimulus, and the two-edge refill shows up as two queued items in a row.

// File: rtl/txdb_pkg.sv
// Package for the transmit double-buffer controller.
// Holds the encoding of why a shift-register load happens.
package txdb_pkg;
    typedef enum logic [1:0] {
        LD_NONE     = 2'd0,
        LD_BYTE_END = 2'd1,
        LD_REFILL   = 2'd2
    } load_src_e;
endpackage

// File: rtl/txdb_hold.sv
// Holding register: captures the CPU byte on an accepted write.
// Assumes the capture strobe is already qualified by mode and enable.
module txdb_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] hold_q
);
    // Capture the written byte; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   hold_q <= '0;
        else if (cap) hold_q <= din;
    end
endmodule

// File: rtl/txdb_flag_ctl.sv
// Empty-flag and load controller. Decides when the holding register moves
// to the shift register and keeps the internal empty flag up to date.
// Assumes all bus-event inputs are single-cycle strobes.
module txdb_flag_ctl
    import txdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic xmit_mode,
    input  logic mod_en,
    input  logic ack_chk_en,
    input  logic ack_bit,
    input  logic byte_done,
    input  logic start_seen,
    input  logic stop_seen,
    output logic wr_acc,
    output logic load_req,
    output logic empty_q
);
    logic      idle_q;
    logic      kill;
    logic      ack_ok;
    load_src_e src;

    // Qualify writes and the clear/priority conditions.
    always_comb begin
        wr_acc = wr_stb && xmit_mode && mod_en;
        kill   = stop_seen || !mod_en;
        ack_ok = !(ack_chk_en && ack_bit);
    end

    // Select the load cause; a kill condition blocks any load.
    always_comb begin
        src = LD_NONE;
        if (!kill && !empty_q) begin
            if (idle_q)                   src = LD_REFILL;
            else if (byte_done && ack_ok) src = LD_BYTE_END;
        end
        load_req = (src != LD_NONE);
    end

    // Update the empty flag: clears win, then write, then set events.
    always_ff @(posedge clk) begin
        if (!rst_n)                     empty_q <= 1'b0;
        else if (kill)                  empty_q <= 1'b0;
        else if (wr_acc)                empty_q <= 1'b0;
        else if (load_req || start_seen) empty_q <= 1'b1;
    end

    // Track whether the shifter is free and waiting for the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        idle_q <= 1'b0;
        else if (kill)     idle_q <= 1'b0;
        else if (load_req) idle_q <= 1'b0;
        else if (start_seen) idle_q <= 1'b1;
        else if (byte_done && empty_q && ack_ok) idle_q <= 1'b1;
    end

    // R8
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen || !mod_en) |=> !empty_q);
    // R2
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && xmit_mode && mod_en) |=> !empty_q);
    // R4
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && !stop_seen && mod_en && !wr_stb) |=> empty_q);
    // R7
    nack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ack_chk_en && ack_bit && !empty_q && !idle_q && !start_seen)
        |=> !empty_q);
    // R10
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !xmit_mode && mod_en && !stop_seen && !start_seen
         && !byte_done && !(idle_q && !empty_q)) |=> $stable(empty_q));
endmodule

// File: rtl/txdb_shift.sv
// Shift register loader: takes the holding byte on a load request and
// raises a one-cycle pulse. Serial shifting is done by the bus engine.
module txdb_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] shift_q,
    output logic              load_pulse_q
);
    // Load the shift register from the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (load_req) shift_q <= hold_q;
    end

    // Mark each load with a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) load_pulse_q <= 1'b0;
        else        load_pulse_q <= load_req;
    end

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (load_pulse_q && shift_q == $past(hold_q)));
endmodule

// File: rtl/txbuf_ctl.sv
// Top of the I2C transmit double-buffer controller. It ties together the
// holding register, the flag/load controller and the shift-register loader.
// Assumes bus events arrive as single-cycle strobes from the bus engine.
module txbuf_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xmit_mode,
    input  logic              mod_en,
    input  logic              ack_chk_en,
    input  logic              byte_done,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              ack_bit,
    output logic [DATA_W-1:0] shift_q,
    output logic              load_pulse,
    output logic              tx_empty
);
    logic              wr_acc;
    logic              load_req;
    logic              empty_q;
    logic [DATA_W-1:0] hold_q;

    txdb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cap(wr_acc), .din(wr_data), .hold_q(hold_q)
    );

    txdb_flag_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .xmit_mode(xmit_mode),
        .mod_en(mod_en), .ack_chk_en(ack_chk_en), .ack_bit(ack_bit),
        .byte_done(byte_done), .start_seen(start_seen), .stop_seen(stop_seen),
        .wr_acc(wr_acc), .load_req(load_req), .empty_q(empty_q)
    );

    txdb_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .hold_q(hold_q),
        .shift_q(shift_q), .load_pulse_q(load_pulse)
    );

    // Show the flag only while in transmit mode.
    always_comb tx_empty = empty_q && xmit_mode;

    // R11
    kill_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen || !mod_en) |=> (!load_pulse && !tx_empty));
endmodule

// File: tb/sim_txbuf_ctl.sv
module sim_txbuf_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 0, xmit_mode = 0, mod_en = 0, ack_chk_en = 0;
    logic       byte_done = 0, start_seen = 0, stop_seen = 0, ack_bit = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] shift_q;
    logic       load_pulse, tx_empty;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        logic       e;
        logic       p;
        logic [7:0] s;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    txbuf_ctl #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .xmit_mode(xmit_mode), .mod_en(mod_en), .ack_chk_en(ack_chk_en),
        .byte_done(byte_done), .start_seen(start_seen), .stop_seen(stop_seen),
        .ack_bit(ack_bit), .shift_q(shift_q), .load_pulse(load_pulse),
        .tx_empty(tx_empty)
    );

    // Driver: apply one cycle of stimulus, queue what is due after the edge.
    task automatic step(input bit wr, input logic [7:0] d, input bit xm,
                        input bit en, input bit ackc, input bit ackb,
                        input bit bd, input bit st, input bit sp,
                        input bit ee, input bit ep, input logic [7:0] es,
                        input string tag);
        exp_t x;
        @(negedge clk);
        wr_stb = wr; wr_data = d; xmit_mode = xm; mod_en = en;
        ack_chk_en = ackc; ack_bit = ackb; byte_done = bd;
        start_seen = st; stop_seen = sp;
        x.e = ee; x.p = ep; x.s = es; x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare outputs 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                compared++;
                if (tx_empty !== x.e || load_pulse !== x.p || shift_q !== x.s) begin
                    mismatched++;
                    $display("FAIL %s: got empty=%b pulse=%b shift=%h, expected empty=%b pulse=%b shift=%h",
                             x.tag, tx_empty, load_pulse, shift_q, x.e, x.p, x.s);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        //    wr d     xm en ac ab bd st sp | e  p  shift
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h00, "R1 reset state");
        step(0, 8'h00, 1, 1, 0, 0, 0, 1, 0,  1, 0, 8'h00, "R4 start sets flag");
        step(1, 8'hA5, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h00, "R2 write clears flag");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  1, 1, 8'hA5, "R4 R3 auto load after start");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  1, 0, 8'hA5, "R3 pulse one cycle");
        step(1, 8'h3C, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'hA5, "R2 write second byte");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'hA5, "R5 waits for byte end");
        step(0, 8'h00, 1, 1, 0, 0, 1, 0, 0,  1, 1, 8'h3C, "R5 byte end loads");
        step(0, 8'h00, 1, 1, 0, 0, 1, 0, 0,  1, 0, 8'h3C, "R6 byte end with flag 1");
        step(1, 8'h77, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h3C, "R6 flag drops one cycle");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  1, 1, 8'h77, "R6 refill load");
        step(1, 8'h11, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h77, "R2 write 11");
        step(0, 8'h00, 1, 1, 1, 1, 1, 0, 0,  0, 0, 8'h77, "R7 nack blocks");
        step(0, 8'h00, 1, 1, 0, 1, 1, 0, 0,  1, 1, 8'h11, "R7 ack ignored when off");
        step(1, 8'h22, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h11, "R2 write 22");
        step(1, 8'h99, 0, 1, 0, 0, 0, 0, 0,  0, 0, 8'h11, "R10 R9 write in receive mode");
        step(0, 8'h00, 1, 1, 0, 0, 1, 0, 0,  1, 1, 8'h22, "R10 ignored byte not loaded");
        step(0, 8'h00, 0, 1, 0, 0, 0, 0, 0,  0, 0, 8'h22, "R9 flag hidden in receive");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  1, 0, 8'h22, "R9 flag shown again");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 1,  0, 0, 8'h22, "R8 stop clears");
        step(0, 8'h00, 1, 1, 0, 0, 0, 1, 0,  1, 0, 8'h22, "R4 start again");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 0,  0, 0, 8'h22, "R8 disable clears");
        step(1, 8'h44, 1, 0, 0, 0, 0, 0, 0,  0, 0, 8'h22, "R10 write while disabled");
        step(0, 8'h00, 1, 1, 0, 0, 0, 1, 1,  0, 0, 8'h22, "R11 stop beats start");
        step(0, 8'h00, 1, 1, 0, 0, 0, 1, 0,  1, 0, 8'h22, "R4 start after stop");
        step(1, 8'h66, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h22, "R2 write 66");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 1,  0, 0, 8'h22, "R11 stop beats refill");
        step(0, 8'h00, 1, 1, 0, 0, 0, 0, 0,  0, 0, 8'h22, "R8 idle cancelled");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule